// File: doc/BRIEF.md
# Warp Memory Request Coalescer

The coalescer accepts one memory instruction for a whole warp of 32 lanes: a mask of active lanes, one byte address per lane and a single access width shared by the lanes. It groups the active lanes by the 128-byte aligned line their address falls in. For every distinct line it issues exactly one request downstream. Each request carries the line index, a four-bit mask of the 32-byte sectors within that line that the grouped lanes touch, and the set of lanes it serves, so that returning data can later be routed back to its lanes.

Requests leave over a valid/ready handshake. The lowest line still pending goes first, and there is at most one request per cycle. A warp whose lanes all fall into one line costs a single request. A warp scattered over N lines costs N requests. When the last request of a warp has been accepted, the block pulses `done` and becomes ready for the next warp in that same cycle. A warp with no active lane produces no request and only the `done` pulse.

Lane addresses must be naturally aligned to the access width, so a lane access never straddles a sector boundary. The sector index of a lane is therefore just address bits [6:5].

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1, `req_valid` is 0 and `done` is 0.
- R2: `in_ready` is 1 exactly when no warp is being served. A warp is taken on a cycle with `in_valid` and `in_ready` both high. No request is presented while `in_ready` is high.
- R3: Each request's `req_line` equals address bits [31:7] of the lanes it serves. `req_lanes` holds every still-pending active lane whose address lies in that line, and only those lanes.
- R4: Bit k of `req_sectors` is set if and only if at least one lane in `req_lanes` has address bits [6:5] equal to k. It is never zero on a valid request.
- R5: The lines of one warp are issued in strictly ascending order. The number of accepted requests equals the number of distinct lines among the active lanes.
- R6: Inactive lanes affect nothing. They never appear in `req_lanes`, and their addresses never create or alter a request.
- R7: While `req_valid` is high and `req_ready` is low, the request stays valid and unchanged on the next cycle.
- R8: `done` is high for exactly one cycle. That cycle follows the acceptance of the warp's last request, and `in_ready` is high in it.
- R9: A warp with an all-zero lane mask issues no request. `done` is high in the cycle after that warp is accepted.
- R10: The access width is coded 0 for 32-bit, 1 for 64-bit and 2 for 128-bit. Each request reports the width of its warp on `req_size`. Active lane addresses must be aligned to that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Warp instruction offered |
| in_ready | output | 1 | Block idle, warp can be taken |
| in_mask | input | 32 | Active lane mask, bit i for lane i |
| in_addr | input | 1024 | Lane byte addresses, lane i in bits [32i+31:32i] |
| in_size | input | 2 | Access width code (0: 32-bit, 1: 64-bit, 2: 128-bit) |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_line | output | 25 | 128-byte line index (address bits [31:7]) |
| req_sectors | output | 4 | Needed 32-byte sectors of the line |
| req_lanes | output | 32 | Lanes served by this request |
| req_size | output | 2 | Access width code of the warp |
| done | output | 1 | One-cycle pulse when the warp is fully served |

## Verification
On every cycle, the assertions check the handshake rules: a held request is stable, lines of a warp rise strictly, no request appears while idle or while `done` is high, every valid request has lanes and sectors, and input addresses are aligned. The grouping itself can only be shown by the bench's scenarios, which compare every accepted request against a line list computed from the lane addresses. Those scenarios also show that inactive lanes are excluded, that the request count is minimal and that the `done` pulse is timed correctly. They run unit strides, reversed strides, broadcasts and clustered or fully random scatter under several masks and back-pressure patterns.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    ACC_W32  = 2'd0,
    ACC_W64  = 2'd1,
    ACC_W128 = 2'd2,
    ACC_BAD  = 2'd3
  } acc_width_e;

  // Low address bits that must be zero for a naturally aligned access.
  function automatic logic [7:0] align_bits(input logic [1:0] width);
    case (acc_width_e'(width))
      ACC_W32:  align_bits = 8'h03;
      ACC_W64:  align_bits = 8'h07;
      default:  align_bits = 8'h0F;
    endcase
  endfunction

endpackage

// File: rtl/coal_min_find.sv
module coal_min_find #(
  parameter int LANES  = 32,
  parameter int LINE_W = 25
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*LINE_W-1:0] lines,
  output logic                    found,
  output logic [LINE_W-1:0]       min_line
);

  always_comb begin
    found    = 1'b0;
    min_line = '1;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && (!found || lines[i*LINE_W +: LINE_W] < min_line)) begin
        min_line = lines[i*LINE_W +: LINE_W];
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/coal_group.sv
module coal_group #(
  parameter int LANES  = 32,
  parameter int SA_W   = 27,
  parameter int SIDX_W = 2
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*SA_W-1:0]   sect_addr,
  input  logic [SA_W-SIDX_W-1:0]  sel_line,
  output logic [LANES-1:0]        hit,
  output logic [(1<<SIDX_W)-1:0]  sectors
);

  localparam int NSECT  = 1 << SIDX_W;
  localparam int LINE_W = SA_W - SIDX_W;

  logic [NSECT-1:0] lane_sect [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SA_W-1:0] sa;
    assign sa           = sect_addr[i*SA_W +: SA_W];
    assign hit[i]       = pend[i] && (sa[SA_W-1 -: LINE_W] == sel_line);
    assign lane_sect[i] = hit[i] ? (NSECT'(1) << sa[SIDX_W-1:0]) : '0;
  end

  always_comb begin
    sectors = '0;
    for (int i = 0; i < LANES; i++) sectors = sectors | lane_sect[i];
  end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic [LANES-1:0]                        in_mask,
  input  logic [LANES*ADDR_W-1:0]                 in_addr,
  input  logic [1:0]                              in_size,
  output logic                                    req_valid,
  input  logic                                    req_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    req_line,
  output logic [LINE_BYTES/SECTOR_BYTES-1:0]      req_sectors,
  output logic [LANES-1:0]                        req_lanes,
  output logic [1:0]                              req_size,
  output logic                                    done
);

  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int SECT_LSB = $clog2(SECTOR_BYTES);
  localparam int SIDX_W   = LINE_LSB - SECT_LSB;
  localparam int LINE_W   = ADDR_W - LINE_LSB;
  localparam int SA_W     = ADDR_W - SECT_LSB;

  // state registers
  logic             busy_q, busy_nxt;
  logic             done_q, done_nxt;
  logic [LANES-1:0] pend_q, pend_nxt;
  logic [1:0]       size_q;
  logic [SA_W-1:0]  sa_q [LANES];

  // datapath
  logic [LANES*SA_W-1:0]   sa_flat;
  logic [LANES*LINE_W-1:0] line_flat;
  logic                    found;
  logic [LINE_W-1:0]       min_line;
  logic [LANES-1:0]        hit;
  logic [(1<<SIDX_W)-1:0]  sectors;
  logic                    in_fire, req_fire, load_en;
  logic                    in_misalign;

  for (genvar i = 0; i < LANES; i++) begin : g_flat
    assign sa_flat[i*SA_W +: SA_W]       = sa_q[i];
    assign line_flat[i*LINE_W +: LINE_W] = sa_q[i][SA_W-1 -: LINE_W];
  end

  coal_min_find #(.LANES(LANES), .LINE_W(LINE_W)) u_min (
    .pend     (pend_q),
    .lines    (line_flat),
    .found    (found),
    .min_line (min_line)
  );

  coal_group #(.LANES(LANES), .SA_W(SA_W), .SIDX_W(SIDX_W)) u_group (
    .pend      (pend_q),
    .sect_addr (sa_flat),
    .sel_line  (min_line),
    .hit       (hit),
    .sectors   (sectors)
  );

  assign in_ready    = !busy_q;
  assign in_fire     = in_valid && in_ready;
  assign load_en     = in_fire;
  assign req_valid   = busy_q && found;
  assign req_fire    = req_valid && req_ready;
  assign req_line    = min_line;
  assign req_sectors = sectors;
  assign req_lanes   = hit;
  assign req_size    = size_q;
  assign done        = done_q;

  // next state
  always_comb begin
    busy_nxt = busy_q;
    pend_nxt = pend_q;
    done_nxt = 1'b0;
    if (in_fire) begin
      pend_nxt = in_mask;
      busy_nxt = |in_mask;
      done_nxt = ~|in_mask;
    end else if (req_fire) begin
      pend_nxt = pend_q & ~hit;
      if (pend_nxt == '0) begin
        busy_nxt = 1'b0;
        done_nxt = 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
    end else begin
      busy_q <= busy_nxt;
      done_q <= done_nxt;
      pend_q <= pend_nxt;
    end
  end

  // warp operand registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= 2'd0;
      for (int i = 0; i < LANES; i++) sa_q[i] <= '0;
    end else if (load_en) begin
      size_q <= in_size;
      for (int i = 0; i < LANES; i++) sa_q[i] <= in_addr[i*ADDR_W+SECT_LSB +: SA_W];
    end
  end

  // input alignment rule
  always_comb begin
    in_misalign = (in_size == 2'd3);
    for (int i = 0; i < LANES; i++) begin
      if (in_mask[i] && ((in_addr[i*ADDR_W +: SECT_LSB] & SECT_LSB'(coal_pkg::align_bits(in_size))) != '0))
        in_misalign = 1'b1;
    end
  end

  AST_IN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) in_fire |-> !in_misalign); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> !req_valid); // R2
  AST_BUSY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) !in_ready |-> req_valid); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_ready) |=> (req_valid && $stable(req_line) && $stable(req_sectors) && $stable(req_lanes))); // R7
  AST_LINE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n) req_fire |=> (!req_valid || (req_line > $past(req_line)))); // R5
  AST_SECT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> (req_sectors != '0)); // R4
  AST_LANES_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> (req_lanes != '0)); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (in_ready && !req_valid)); // R8

endmodule

// File: tb/warp_coalescer_bench.sv
`timescale 1ns/1ps
module warp_coalescer_bench;

  localparam int L = 32;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [L-1:0]  in_mask;
  logic [L*32-1:0] in_addr;
  logic [1:0]    in_size;
  logic          req_valid;
  logic          req_ready;
  logic [24:0]   req_line;
  logic [3:0]    req_sectors;
  logic [L-1:0]  req_lanes;
  logic [1:0]    req_size;
  logic          done;

  int checks;
  int errors;

  logic [31:0] a [L];
  logic [24:0] exp_line [L];
  logic [3:0]  exp_sect [L];
  logic [L-1:0] exp_lanes [L];
  int          exp_n;

  warp_coalescer u_warp_coalescer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_addr(in_addr), .in_size(in_size),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_sectors(req_sectors),
    .req_lanes(req_lanes), .req_size(req_size),
    .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected request list: distinct lines of active lanes, ascending.
  task automatic build_expect(input logic [L-1:0] mask);
    logic [L-1:0] left;
    logic [24:0]  lo;
    left  = mask;
    exp_n = 0;
    while (left != '0) begin
      lo = '1;
      for (int i = 0; i < L; i++) if (left[i] && a[i][31:7] < lo) lo = a[i][31:7];
      exp_line[exp_n]  = lo;
      exp_sect[exp_n]  = '0;
      exp_lanes[exp_n] = '0;
      for (int i = 0; i < L; i++) begin
        if (left[i] && a[i][31:7] == lo) begin
          exp_lanes[exp_n][i] = 1'b1;
          exp_sect[exp_n][a[i][6:5]] = 1'b1;
        end
      end
      left = left & ~exp_lanes[exp_n];
      exp_n++;
    end
  endtask

  task automatic run_warp(input logic [L-1:0] mask, input logic [1:0] size, input int rmode);
    int idx;
    int guard;
    bit held;
    logic [24:0] h_line;
    logic [3:0]  h_sect;
    logic [L-1:0] h_lanes;
    logic [24:0] prev_line;
    build_expect(mask);
    @(negedge clk);
    in_valid = 1'b1;
    in_mask  = mask;
    in_size  = size;
    for (int i = 0; i < L; i++) in_addr[i*32 +: 32] = a[i];
    #1;
    chk(in_ready == 1'b1, "R2 in_ready idle", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_mask  = '0;
    if (exp_n == 0) begin
      req_ready = 1'b1;
      #1;
      chk(done == 1'b1 && req_valid == 1'b0, "R9 empty warp done", {62'd0, done, req_valid}, 64'h2);
    end else begin
      idx = 0;
      held = 1'b0;
      guard = 0;
      prev_line = '0;
      while (idx < exp_n && guard < 2000) begin
        guard++;
        req_ready = (rmode == 0) ? 1'b1 : (rmode == 1 ? 1'($urandom % 2) : 1'(guard % 3 == 0));
        #1;
        if (!req_valid) begin
          chk(1'b0, "R2 request missing while busy", 64'(req_valid), 64'd1);
        end else begin
          if (held)
            chk(req_line == h_line && req_sectors == h_sect && req_lanes == h_lanes,
                "R7 held request stable", 64'(req_line), 64'(h_line));
          if (req_ready) begin
            chk(in_ready == 1'b0, "R2 in_ready low while busy", 64'(in_ready), 64'd0);
            chk(req_line == exp_line[idx], "R3 line index", 64'(req_line), 64'(exp_line[idx]));
            chk(req_lanes == exp_lanes[idx], "R6 lane group", 64'(req_lanes), 64'(exp_lanes[idx]));
            chk(req_sectors == exp_sect[idx], "R4 sector mask", 64'(req_sectors), 64'(exp_sect[idx]));
            chk(req_size == size, "R10 size echo", 64'(req_size), 64'(size));
            if (idx > 0) chk(req_line > prev_line, "R5 ascending", 64'(req_line), 64'(prev_line));
            prev_line = req_line;
            idx++;
            held = 1'b0;
          end else begin
            held    = 1'b1;
            h_line  = req_line;
            h_sect  = req_sectors;
            h_lanes = req_lanes;
          end
        end
        @(negedge clk);
      end
      chk(idx == exp_n, "R5 request count", 64'(idx), 64'(exp_n));
      req_ready = 1'b0;
      #1;
      chk(done == 1'b1 && in_ready == 1'b1 && req_valid == 1'b0, "R8 done after last",
          {61'd0, done, in_ready, req_valid}, 64'h6);
    end
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
  endtask

  // Address pattern generator; addresses aligned to the access width.
  task automatic gen(input int mode, input logic [1:0] size, input logic [L-1:0] mask);
    int bytes;
    logic [31:0] base;
    logic [31:0] almask;
    bytes  = 4 << size;
    almask = ~32'(bytes - 1);
    base   = $urandom & almask;
    if (base > 32'hFFFF_F000) base = base - 32'h0000_1000;
    for (int i = 0; i < L; i++) begin
      case (mode)
        0: a[i] = base + 32'(i * bytes);
        1: a[i] = base + 32'((L - 1 - i) * bytes);
        2: a[i] = base;
        3: a[i] = (32'h4000_0000 | 32'(($urandom % 8) << 7) | 32'($urandom % 128)) & almask;
        default: a[i] = $urandom & almask;
      endcase
      // Inactive lanes point to far-away lines that must not appear.
      if (!mask[i]) a[i] = 32'hF000_0000 + 32'(i << 9);
    end
  endtask

  function automatic logic [L-1:0] pick_mask(input int mm);
    case (mm)
      0: pick_mask = '1;
      1: pick_mask = $urandom;
      2: pick_mask = 32'h5555_5555;
      3: pick_mask = 32'(1) << ($urandom % L);
      default: pick_mask = '0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [L-1:0] m;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_mask = '0;
    in_addr = '0;
    in_size = 2'd0;
    req_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0, "R1 reset state",
        {61'd0, in_ready, req_valid, done}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0, "R1 after release",
        {61'd0, in_ready, req_valid, done}, 64'h4);

    // Fully coalesced: 32 lanes x 4 bytes in one aligned line, all sectors.
    for (int i = 0; i < L; i++) a[i] = 32'h0000_1000 + 32'(i * 4);
    build_expect('1);
    chk(exp_n == 1 && exp_sect[0] == 4'hF, "R5 single line expectation", 64'(exp_n), 64'd1);
    run_warp('1, 2'd0, 0);

    // Broadcast into sector 2 only.
    for (int i = 0; i < L; i++) a[i] = 32'h0000_2040;
    run_warp('1, 2'd0, 1);

    // 128-bit stride, 4 lines, reversed lane order.
    for (int i = 0; i < L; i++) a[i] = 32'h0001_0000 + 32'((L - 1 - i) * 16);
    run_warp('1, 2'd2, 2);

    // Sweep of patterns, widths, masks and back-pressure styles.
    for (int mode = 0; mode < 5; mode++)
      for (int sz = 0; sz < 3; sz++)
        for (int mm = 0; mm < 5; mm++)
          for (int rep = 0; rep < 4; rep++) begin
            m = pick_mask(mm);
            gen(mode, 2'(sz), m);
            run_warp(m, 2'(sz), rep % 3);
          end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule